// File: doc/BRIEF.md
# Mode-Selected Performance Event Counters

This block is a small performance monitoring unit for a processor core. It holds one cycle counter and two event counters. A two-bit mode field chooses which core events the two event counters track. In one mode they track executed instructions against external instruction line fills. In another they track data cache accesses against data cache misses. In a third they track instruction fetch stall cycles against external line fills. The core drives one-cycle event strobes into the block. A data cache access strobe comes with a count, so that a multi-register transfer adds one per register and a double-word load adds two.

Software controls the unit through a small register port with a synchronous write and a combinational read. It can enable or halt counting, zero every counter, switch the mode and clear the sticky overflow flags. Ratios such as miss rate or cycles per instruction are computed in software from the three counts.

Top module: `perf_event_counters`

## Requirements
- R1: After reset every counter reads 0, counting is disabled, the mode is instruction-cache efficiency (code 0) and all overflow flags are 0. The register map is: address 0 control, address 1 cycle count, address 2 event count A, address 3 event count B. Counters narrower than the data bus read zero-extended.
- R2: While enabled, the cycle counter adds one on every clock edge.
- R3: In mode 0, count A adds one for each cycle `instr_exec_i` is high. Count B adds one for each cycle `ifetch_ext_i` is high. Stall, data access and miss strobes have no effect in this mode.
- R4: In mode 1, count A adds `dc_access_cnt_i` (0 to 16) in each cycle `dc_access_i` is high. When `dc_access_i` is low, the count value is ignored.
- R5: In mode 1, count B adds one for each cycle `dc_miss_i` is high, except in cycles where `cache_op_i` is also high.
- R6: In mode 2, count A adds one for each cycle `ifetch_stall_i` is high. Count B adds one for each cycle `ifetch_ext_i` is high.
- R7: In mode 3, both event counters hold their value, while the cycle counter still advances when enabled.
- R8: While the enable bit is clear, all three counters hold their value regardless of the event strobes.
- R9: Control register fields: bit 0 enable, bit 1 zero-all (write-only, reads 0), bits 3:2 mode, bits 6:4 overflow flags for cycle, A and B. A write takes effect at its clock edge. Strobes in that same cycle are counted under the old mode and enable. A zero-all write leaves every counter at 0, even if an increment fell in that cycle.
- R10: Each counter sets its overflow flag when an increment carries it past all ones, including a multi-count increment that crosses the wrap point. The flag stays set until a control write with a 1 in its bit. If a wrap and such a write fall in the same cycle, the flag is left set.
- R11: Reading any register does not change any counter or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_exec_i | input | 1 | An instruction executed this cycle |
| ifetch_ext_i | input | 1 | An instruction line fill request went to external memory |
| dc_access_i | input | 1 | Data cache access strobe |
| dc_access_cnt_i | input | INC_W | Number of accesses in this cycle (0 to 16) |
| dc_miss_i | input | 1 | Data or mini data cache miss |
| cache_op_i | input | 1 | The current data cache activity is a maintenance operation |
| ifetch_stall_i | input | 1 | The instruction cache could not deliver due to a cache or TLB miss |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational) |

## Verification
A counter wrap and a control write can fall in the same cycle. The bench provokes this in two ways. First, it runs the cycle counter and count A up to all ones, then issues a flag-clearing write on the very edge where both wrap, with an instruction strobe held high. The flags must read set afterwards. Second, it issues a zero-all write while strobes are active and expects the counters to read zero. A mode switch written in a cycle that carries both an instruction strobe and a five-access data strobe must count only the old mode's event.

// File: rtl/perf_pkg.sv
package perf_pkg;
  typedef enum logic [1:0] {
    MODE_ICACHE    = 2'd0,
    MODE_DCACHE    = 2'd1,
    MODE_FETCH_LAT = 2'd2,
    MODE_OFF       = 2'd3
  } perf_mode_e;

  localparam int NUM_CNT = 3;   // 0 cycle, 1 event A, 2 event B
  localparam int ADDR_W  = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_CYC  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_EVA  = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_EVB  = 2'd3;

  localparam int CTRL_EN   = 0;
  localparam int CTRL_CLR  = 1;
  localparam int CTRL_MODE = 2;
  localparam int CTRL_OVF  = 4;
endpackage

// File: rtl/perf_event_sel.sv
module perf_event_sel
  import perf_pkg::*;
#(
  parameter int INC_W = 5
) (
  input  perf_mode_e       mode_i,
  input  logic             instr_exec_i,
  input  logic             ifetch_ext_i,
  input  logic             dc_access_i,
  input  logic [INC_W-1:0] dc_access_cnt_i,
  input  logic             dc_miss_i,
  input  logic             cache_op_i,
  input  logic             ifetch_stall_i,
  output logic [INC_W-1:0] inc_a_o,
  output logic [INC_W-1:0] inc_b_o
);
  localparam logic [INC_W-1:0] ONE  = INC_W'(1);
  localparam logic [INC_W-1:0] NONE = '0;

  always_comb begin
    inc_a_o = NONE;
    inc_b_o = NONE;
    unique case (mode_i)
      MODE_ICACHE: begin
        inc_a_o = instr_exec_i ? ONE : NONE;
        inc_b_o = ifetch_ext_i ? ONE : NONE;
      end
      MODE_DCACHE: begin
        inc_a_o = dc_access_i ? dc_access_cnt_i : NONE;
        // maintenance operations never count as misses
        inc_b_o = (dc_miss_i && !cache_op_i) ? ONE : NONE;
      end
      MODE_FETCH_LAT: begin
        inc_a_o = ifetch_stall_i ? ONE : NONE;
        inc_b_o = ifetch_ext_i ? ONE : NONE;
      end
      MODE_OFF: begin
        inc_a_o = NONE;
        inc_b_o = NONE;
      end
    endcase
  end
endmodule

// File: rtl/perf_counter.sv
module perf_counter #(
  parameter int CNT_W = 32,
  parameter int INC_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   sum;

  // one extra bit catches the carry of any increment up to 2**INC_W-1
  assign sum    = {1'b0, cnt_q} + {{(CNT_W + 1 - INC_W){1'b0}}, inc_i};
  assign wrap_o = en_i & ~clr_i & sum[CNT_W];
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= sum[CNT_W-1:0];
  end
endmodule

// File: rtl/perf_ctrl_regs.sv
module perf_ctrl_regs
  import perf_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int DATA_W = 32
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [DATA_W-1:0]               wdata_i,
  input  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt_i,
  input  logic [NUM_CNT-1:0]              wrap_i,
  output logic                            en_o,
  output logic                            clr_o,
  output perf_mode_e                      mode_o,
  output logic [NUM_CNT-1:0]              ovf_o,
  output logic [DATA_W-1:0]               rdata_o
);
  logic               en_q;
  perf_mode_e         mode_q;
  logic [NUM_CNT-1:0] ovf_q;
  logic               ctrl_wr;
  logic [NUM_CNT-1:0] ovf_w1c;
  logic               unused_wdata;

  assign ctrl_wr      = we_i && (addr_i == ADDR_CTRL);
  assign clr_o        = ctrl_wr && wdata_i[CTRL_CLR];
  assign ovf_w1c      = ctrl_wr ? wdata_i[CTRL_OVF +: NUM_CNT] : '0;
  assign unused_wdata = ^wdata_i[DATA_W-1:CTRL_OVF+NUM_CNT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mode_q <= MODE_ICACHE;
      ovf_q  <= '0;
    end else begin
      if (ctrl_wr) begin
        en_q   <= wdata_i[CTRL_EN];
        mode_q <= perf_mode_e'(wdata_i[CTRL_MODE +: 2]);
      end
      // set has priority over clear
      ovf_q <= (ovf_q & ~ovf_w1c) | wrap_i;
    end
  end

  assign en_o   = en_q;
  assign mode_o = mode_q;
  assign ovf_o  = ovf_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL: begin
        rdata_o[CTRL_EN]              = en_q;
        rdata_o[CTRL_MODE +: 2]       = mode_q;
        rdata_o[CTRL_OVF +: NUM_CNT]  = ovf_q;
      end
      ADDR_CYC: rdata_o[CNT_W-1:0] = cnt_i[0];
      ADDR_EVA: rdata_o[CNT_W-1:0] = cnt_i[1];
      ADDR_EVB: rdata_o[CNT_W-1:0] = cnt_i[2];
    endcase
  end
endmodule

// File: rtl/perf_event_counters.sv
module perf_event_counters
  import perf_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int INC_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              instr_exec_i,
  input  logic              ifetch_ext_i,
  input  logic              dc_access_i,
  input  logic [INC_W-1:0]  dc_access_cnt_i,
  input  logic              dc_miss_i,
  input  logic              cache_op_i,
  input  logic              ifetch_stall_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o
);
  logic                          en_w;
  logic                          clr_w;
  perf_mode_e                    mode_w;
  logic [NUM_CNT-1:0]            ovf_w;
  logic [NUM_CNT-1:0]            wrap_w;
  logic [NUM_CNT-1:0][CNT_W-1:0] cnt_arr;
  logic [NUM_CNT-1:0][INC_W-1:0] inc_arr;

  assign inc_arr[0] = INC_W'(1);

  perf_event_sel #(.INC_W(INC_W)) u_sel (
    .mode_i          (mode_w),
    .instr_exec_i    (instr_exec_i),
    .ifetch_ext_i    (ifetch_ext_i),
    .dc_access_i     (dc_access_i),
    .dc_access_cnt_i (dc_access_cnt_i),
    .dc_miss_i       (dc_miss_i),
    .cache_op_i      (cache_op_i),
    .ifetch_stall_i  (ifetch_stall_i),
    .inc_a_o         (inc_arr[1]),
    .inc_b_o         (inc_arr[2])
  );

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    perf_counter #(.CNT_W(CNT_W), .INC_W(INC_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (en_w),
      .clr_i  (clr_w),
      .inc_i  (inc_arr[i]),
      .cnt_o  (cnt_arr[i]),
      .wrap_o (wrap_w[i])
    );
  end

  perf_ctrl_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .cnt_i   (cnt_arr),
    .wrap_i  (wrap_w),
    .en_o    (en_w),
    .clr_o   (clr_w),
    .mode_o  (mode_w),
    .ovf_o   (ovf_w),
    .rdata_o (reg_rdata_o)
  );
endmodule

// File: rtl/perf_event_counters_chk.sv
module perf_event_counters_chk
  import perf_pkg::*;
#(
  parameter int CNT_W  = 32,
  parameter int INC_W  = 5,
  parameter int DATA_W = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_i,
  input logic               clr_i,
  input perf_mode_e         mode_i,
  input logic [NUM_CNT-1:0] ovf_i,
  input logic [CNT_W-1:0]   cyc_i,
  input logic [CNT_W-1:0]   eva_i,
  input logic [CNT_W-1:0]   evb_i,
  input logic               dc_access_i,
  input logic [INC_W-1:0]   dc_access_cnt_i,
  input logic               cache_op_i,
  input logic               reg_we_i,
  input logic [1:0]         reg_addr_i,
  input logic [DATA_W-1:0]  reg_wdata_i
);
  logic [NUM_CNT-1:0] w1c;
  assign w1c = (reg_we_i && reg_addr_i == ADDR_CTRL) ? reg_wdata_i[CTRL_OVF +: NUM_CNT] : '0;

  assert_cycle_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !clr_i |=> cyc_i == CNT_W'($past(cyc_i) + 1'b1));

  assert_burst_limit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dc_access_i |-> dc_access_cnt_i <= INC_W'(16));

  assert_cacheop_excluded_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !clr_i && mode_i == MODE_DCACHE && cache_op_i |=> $stable(evb_i));

  assert_off_mode_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !clr_i && mode_i == MODE_OFF |=> $stable(eva_i) && $stable(evb_i));

  assert_disabled_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i && !clr_i |=> $stable(cyc_i) && $stable(eva_i) && $stable(evb_i));

  assert_zero_all_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cyc_i == '0 && eva_i == '0 && evb_i == '0);

  assert_flag_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_i & ~w1c) != '0 |=> (ovf_i & $past(ovf_i & ~w1c)) == $past(ovf_i & ~w1c));
endmodule

bind perf_event_counters perf_event_counters_chk #(
  .CNT_W(CNT_W), .INC_W(INC_W), .DATA_W(DATA_W)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .en_i            (en_w),
  .clr_i           (clr_w),
  .mode_i          (mode_w),
  .ovf_i           (ovf_w),
  .cyc_i           (cnt_arr[0]),
  .eva_i           (cnt_arr[1]),
  .evb_i           (cnt_arr[2]),
  .dc_access_i     (dc_access_i),
  .dc_access_cnt_i (dc_access_cnt_i),
  .cache_op_i      (cache_op_i),
  .reg_we_i        (reg_we_i),
  .reg_addr_i      (reg_addr_i),
  .reg_wdata_i     (reg_wdata_i)
);

// File: tb/perf_event_counters_test.sv
module perf_event_counters_test;
  localparam int CNT_W  = 8;
  localparam int INC_W  = 5;
  localparam int DATA_W = 32;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              instr_exec_i = 0, ifetch_ext_i = 0, dc_access_i = 0;
  logic [INC_W-1:0]  dc_access_cnt_i = '0;
  logic              dc_miss_i = 0, cache_op_i = 0, ifetch_stall_i = 0;
  logic              reg_we_i = 0;
  logic [1:0]        reg_addr_i = '0;
  logic [DATA_W-1:0] reg_wdata_i = '0;
  logic [DATA_W-1:0] reg_rdata_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #5 clk_i = ~clk_i;

  perf_event_counters #(.CNT_W(CNT_W), .INC_W(INC_W), .DATA_W(DATA_W)) uut (.*);

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic rd_chk(input logic [1:0] a, input string tag, input logic [31:0] exp);
    reg_addr_i = a;
    #1;
    check(tag, reg_rdata_o, exp);
  endtask

  task automatic idle_ev();
    instr_exec_i = 0; ifetch_ext_i = 0; dc_access_i = 0; dc_access_cnt_i = '0;
    dc_miss_i = 0; cache_op_i = 0; ifetch_stall_i = 0;
  endtask

  // one edge; event inputs set beforehand are sampled at it
  task automatic wr(input logic [31:0] d);
    reg_we_i = 1; reg_addr_i = 2'd0; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 0; reg_wdata_i = '0;
    idle_ev();
  endtask

  task automatic step(input logic ex, input logic ext, input logic acc, input logic [4:0] cnt,
                      input logic miss, input logic cop, input logic stall);
    instr_exec_i = ex; ifetch_ext_i = ext; dc_access_i = acc; dc_access_cnt_i = cnt;
    dc_miss_i = miss; cache_op_i = cop; ifetch_stall_i = stall;
    @(negedge clk_i);
    idle_ev();
  endtask

  task automatic t_reset();
    rd_chk(2'd0, "R1 ctrl", 32'h0);
    rd_chk(2'd1, "R1 cycle", 32'h0);
    rd_chk(2'd2, "R1 evA", 32'h0);
    rd_chk(2'd3, "R1 evB", 32'h0);
  endtask

  task automatic t_icache();
    wr(32'h3);
    step(1,0,1,3,1,0,1); step(0,1,0,0,1,0,1); step(1,0,0,0,0,0,1);
    rd_chk(2'd2, "R11 evA mid-run", 32'd2);
    step(1,0,1,4,1,0,0); step(0,1,0,0,0,0,1); step(1,0,0,0,0,0,0);
    wr(32'h0);
    rd_chk(2'd1, "R2 cycle count", 32'd7);
    rd_chk(2'd2, "R3 executed", 32'd4);
    rd_chk(2'd3, "R3 line fills", 32'd2);
  endtask

  task automatic t_dcache();
    wr(32'h7);
    step(1,1,1,5'd1,0,0,1);
    step(1,1,1,5'd2,1,0,1);
    step(1,1,1,5'd7,1,1,1);
    step(1,1,0,5'd0,0,1,1);
    step(1,1,1,5'd16,1,0,1);
    step(1,1,0,5'd5,0,0,1);
    step(1,1,1,5'd0,0,0,1);
    wr(32'h4);
    rd_chk(2'd2, "R4 access sum", 32'd26);
    rd_chk(2'd3, "R5 misses", 32'd2);
    rd_chk(2'd1, "R2 cycle dcache", 32'd8);
  endtask

  task automatic t_latency();
    wr(32'hB);
    step(1,0,1,3,1,0,1); step(1,1,1,3,1,0,1); step(1,0,0,0,0,0,1);
    step(1,0,0,0,1,0,0); step(1,1,0,0,0,0,1);
    wr(32'h8);
    rd_chk(2'd2, "R6 stall cycles", 32'd4);
    rd_chk(2'd3, "R6 line fills", 32'd2);
  endtask

  task automatic t_off_mode();
    wr(32'hF);
    for (int i = 0; i < 4; i++) step(1,1,1,5'd9,1,0,1);
    wr(32'hC);
    rd_chk(2'd2, "R7 evA held", 32'd0);
    rd_chk(2'd3, "R7 evB held", 32'd0);
    rd_chk(2'd1, "R7 cycle runs", 32'd5);
  endtask

  task automatic t_disabled_hold();
    wr(32'h3);
    for (int i = 0; i < 3; i++) step(1,1,0,0,0,0,0);
    wr(32'h0);
    for (int i = 0; i < 5; i++) step(1,1,1,5'd4,1,0,1);
    rd_chk(2'd1, "R8 cycle held", 32'd4);
    rd_chk(2'd2, "R8 evA held", 32'd3);
    rd_chk(2'd3, "R8 evB held", 32'd3);
    rd_chk(2'd0, "R9 ctrl readback", 32'h0);
  endtask

  task automatic t_mode_switch();
    wr(32'h3);
    instr_exec_i = 1; dc_access_i = 1; dc_access_cnt_i = 5'd5;
    wr(32'h5);
    step(1,0,1,5'd5,0,0,0);
    wr(32'h4);
    rd_chk(2'd2, "R9 old mode at write edge", 32'd6);
    rd_chk(2'd1, "R9 cycle", 32'd3);
    rd_chk(2'd0, "R9 mode field", 32'h4);
  endtask

  task automatic t_clear_priority();
    wr(32'h3);
    step(1,0,0,0,0,0,0); step(1,0,0,0,0,0,0);
    instr_exec_i = 1;
    wr(32'h3);
    wr(32'h0);
    rd_chk(2'd2, "R9 zero-all beats increment", 32'd0);
    rd_chk(2'd1, "R9 cycle after zero-all", 32'd1);
  endtask

  task automatic t_wrap_burst();
    wr(32'h77);
    for (int i = 0; i < 15; i++) step(0,0,1,5'd16,0,0,0);
    step(0,0,1,5'd10,0,0,0);
    rd_chk(2'd2, "R10 evA below wrap", 32'd250);
    rd_chk(2'd0, "R10 no flag yet", 32'h5);
    step(0,0,1,5'd16,0,0,0);
    wr(32'h4);
    rd_chk(2'd2, "R10 evA after burst wrap", 32'd10);
    rd_chk(2'd0, "R10 evA flag set", 32'h24);
    rd_chk(2'd1, "R10 cycle", 32'd18);
    wr(32'h24);
    rd_chk(2'd0, "R10 flag cleared", 32'h4);
  endtask

  task automatic t_wrap_vs_clear();
    wr(32'h73);
    for (int i = 0; i < 255; i++) step(1,0,0,0,0,0,0);
    rd_chk(2'd2, "R10 evA at max", 32'd255);
    rd_chk(2'd1, "R10 cycle at max", 32'd255);
    instr_exec_i = 1;
    wr(32'h21);
    wr(32'h0);
    rd_chk(2'd0, "R10 set wins over clear", 32'h30);
    rd_chk(2'd2, "R10 evA wrapped", 32'd0);
    rd_chk(2'd1, "R10 cycle wrapped", 32'd1);
    wr(32'h70);
    rd_chk(2'd0, "R10 flags cleared", 32'h0);
  endtask

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_icache();
    t_dcache();
    t_latency();
    t_off_mode();
    t_disabled_hold();
    t_mode_switch();
    t_clear_priority();
    t_wrap_burst();
    t_wrap_vs_clear();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule